// File: doc/BRIEF.md
# Floating-Point Exception Trap Controller

This block sits at the retirement point of a floating-point unit and rules on every finished operation or conditional test. From the exception conditions the datapath detected, the enable mask held in its control register and the kind of instruction involved, it decides three things: whether a trap is requested, whether the destination register is written, and whether the written value is the datapath result or the default result. It also keeps the sticky exception status bits and the address of the instruction that trapped.

Exceptions come in two kinds. Input exceptions (unordered branch, input NaN, input denormal) are pre-instruction: when they are enabled the default result is still written before the trap. Result exceptions (operand error, overflow, underflow, divide-by-zero, inexact) are post-instruction: when they are enabled the destination is left untouched. A conditional test whose predicate ignores IEEE ordering raises the unordered-branch exception when the NaN condition code is set. Any exception that is still pending is serviced before that test is evaluated. A save clears the enable mask. A restore reloads the status bits and traps again if a restored bit is enabled.

Every output is registered and reflects the inputs sampled at the previous rising clock edge.

Top module: `fpx_trap_ctrl`

## Requirements
- R1: While `rst` is high, and at the first edge after it falls, `trap_req`, `dst_we`, `dst_dflt` and `cond_ok` are 0, and `ctrl_q`, `stat_q` and `fiar_q` are 0.
- R2: Exception bit positions, shared by `raw_exc`, `ctrl_q` and `stat_q`: 7 unordered branch, 6 input NaN, 5 input denormal, 4 operand error, 3 overflow, 2 underflow, 1 divide-by-zero, 0 inexact. An arithmetic operation (`op_class` 0) sets every raised bit in `stat_q` one cycle later. A raw bit 4, 3, 2, 1 or 5 also sets bit 0, and a raw bit 6 also sets bit 5.
- R3: For an arithmetic operation whose raised bits are all disabled in `ctrl_q`, no trap is requested and `dst_we` is 1. `dst_dflt` is 1 if any bit was raised and 0 if none was.
- R4: For an arithmetic operation where only pre-instruction bits (7..5) are enabled and raised, `trap_req`, `dst_we` and `dst_dflt` are all 1.
- R5: For an arithmetic operation where any post-instruction bit (4..0) is enabled and raised, `trap_req` is 1 and `dst_we` and `dst_dflt` are 0. This holds even when enabled pre-instruction bits are raised as well.
- R6: A conditional test (`op_class` 1) with no pending exception sets status bit 7 when `pred_aware` is 0 and `cc_nan` is 1. It then requests a trap only if bit 7 is enabled, and `cond_ok` is the inverse of that trap. A conditional test never asserts `dst_we`.
- R7: A conditional test issued while `stat_q & ctrl_q` is nonzero requests a trap, leaves `cond_ok` 0 and `stat_q` unchanged, and does not evaluate the predicate.
- R8: Control/status register moves (`op_class` 2) and multi data-register moves (`op_class` 5) never request a trap, never assert `dst_we`, and leave `stat_q` unchanged, even while an enabled exception is pending.
- R9: A save (`op_class` 3) clears `ctrl_q` one cycle later, overriding a control write in the same cycle.
- R10: A restore (`op_class` 4) loads `stat_q` from `raw_exc`, overriding a status write in the same cycle. It requests a trap if any loaded bit is enabled in `ctrl_q`.
- R11: `fiar_q` takes `op_addr` in the same cycle that `trap_req` rises. When there is no trap it changes only by `fiar_wr`, and a trap wins over a write in the same cycle.
- R12: Status bits are sticky. They fall only through `stat_wr` or a restore. A status write in the same cycle as an operation is merged with that operation's newly raised bits.
- R13: Raw bit 7 presented with an arithmetic operation is ignored: it sets no status bit and causes no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A completed operation is presented this cycle |
| op_class | input | 3 | Instruction class code (0..5, see R2–R10) |
| op_addr | input | ADDR_W | Address of the presented instruction |
| raw_exc | input | 8 | Detected exception conditions, or the status image on a restore |
| pred_aware | input | 1 | Conditional predicate is IEEE-aware |
| cc_nan | input | 1 | NaN condition-code bit |
| ctrl_wr | input | 1 | Write enable-mask register |
| ctrl_wdata | input | 8 | Enable-mask write data |
| stat_wr | input | 1 | Write status register |
| stat_wdata | input | 8 | Status write data |
| fiar_wr | input | 1 | Write faulting-address register |
| fiar_wdata | input | ADDR_W | Faulting-address write data |
| trap_req | output | 1 | Trap request, one cycle per trapping operation |
| dst_we | output | 1 | Destination write enable |
| dst_dflt | output | 1 | Write selects the default result |
| cond_ok | output | 1 | Conditional test may take effect |
| ctrl_q | output | 8 | Enable mask |
| stat_q | output | 8 | Sticky exception status |
| fiar_q | output | ADDR_W | Faulting instruction address |

## Verification
The assertions assume that `op_class` only carries the six defined codes and that `rst` is asserted for at least one edge before checking starts. The stimulus draws the class from those six codes only and holds reset for several cycles. The raw exception bits are drawn sparsely, so that disabled, pre-only, post-only and mixed cases all occur. Software writes to the mask, the status and the address are mixed in at a low rate, so that the collisions with saves, restores and traps named in R9–R12 are hit without crowding out plain operations.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int EXC_W = 8;

    localparam int XB_UNORD = 7;
    localparam int XB_NANIN = 6;
    localparam int XB_DENIN = 5;
    localparam int XB_OPERR = 4;
    localparam int XB_OVF   = 3;
    localparam int XB_UNF   = 2;
    localparam int XB_DIVZ  = 1;
    localparam int XB_INEX  = 0;

    typedef logic [EXC_W-1:0] exc_t;

    localparam exc_t PRE_MASK  = exc_t'((1 << XB_UNORD) | (1 << XB_NANIN) | (1 << XB_DENIN));
    localparam exc_t POST_MASK = ~PRE_MASK;

    typedef enum logic [2:0] {
        OPC_ARITH   = 3'd0,
        OPC_COND    = 3'd1,
        OPC_CREG    = 3'd2,
        OPC_SAVE    = 3'd3,
        OPC_RESTORE = 3'd4,
        OPC_MREG    = 3'd5
    } opc_e;

    typedef struct packed {
        logic trap;
        logic dst_we;
        logic dst_dflt;
        logic cond_ok;
        exc_t set_bits;
    } verdict_t;

    // Applies the paired-bit rules to a raw arithmetic exception vector.
    function automatic exc_t widen_exc(input exc_t raw);
        exc_t w;
        w = raw;
        w[XB_UNORD] = 1'b0;
        if (raw[XB_NANIN])
            w[XB_DENIN] = 1'b1;
        if (raw[XB_OPERR] | raw[XB_OVF] | raw[XB_UNF] | raw[XB_DIVZ] | raw[XB_DENIN])
            w[XB_INEX] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/fpx_arith_judge.sv
module fpx_arith_judge
    import fpx_pkg::*;
(
    input  exc_t     raw,
    input  exc_t     enables,
    output verdict_t verdict
);
    exc_t raised;
    exc_t armed;
    logic post_hit;

    always_comb begin
        raised   = widen_exc(raw);
        armed    = raised & enables;
        post_hit = |(armed & POST_MASK);

        verdict          = '0;
        verdict.set_bits = raised;
        verdict.trap     = |armed;
        verdict.dst_we   = ~post_hit;
        verdict.dst_dflt = ~post_hit & (|raised);
        verdict.cond_ok  = 1'b0;
    end
endmodule

// File: rtl/fpx_cond_judge.sv
module fpx_cond_judge
    import fpx_pkg::*;
(
    input  exc_t     status,
    input  exc_t     enables,
    input  logic     pred_aware,
    input  logic     cc_nan,
    output verdict_t verdict
);
    logic pending;
    logic unord;

    always_comb begin
        pending = |(status & enables);
        unord   = ~pred_aware & cc_nan;
        verdict = '0;
        if (pending) begin
            verdict.trap    = 1'b1;
            verdict.cond_ok = 1'b0;
        end else begin
            verdict.set_bits[XB_UNORD] = unord;
            verdict.trap               = unord & enables[XB_UNORD];
            verdict.cond_ok            = ~(unord & enables[XB_UNORD]);
        end
        verdict.dst_we   = 1'b0;
        verdict.dst_dflt = 1'b0;
    end
endmodule

// File: rtl/fpx_state_regs.sv
module fpx_state_regs
    import fpx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  exc_t              ctrl_wdata,
    input  logic              stat_wr,
    input  exc_t              stat_wdata,
    input  logic              fiar_wr,
    input  logic [ADDR_W-1:0] fiar_wdata,
    input  logic              save_clr,
    input  logic              rest_ld,
    input  exc_t              rest_val,
    input  exc_t              set_bits,
    input  logic              trap,
    input  logic [ADDR_W-1:0] op_addr,
    output exc_t              ctrl_q,
    output exc_t              stat_q,
    output logic [ADDR_W-1:0] fiar_q
);
    exc_t              ctrl_n;
    exc_t              stat_n;
    logic [ADDR_W-1:0] fiar_n;

    always_comb begin
        if (save_clr)     ctrl_n = '0;
        else if (ctrl_wr) ctrl_n = ctrl_wdata;
        else              ctrl_n = ctrl_q;

        if (rest_ld)      stat_n = rest_val;
        else              stat_n = (stat_wr ? stat_wdata : stat_q) | set_bits;

        if (trap)         fiar_n = op_addr;
        else if (fiar_wr) fiar_n = fiar_wdata;
        else              fiar_n = fiar_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
            fiar_q <= '0;
        end else begin
            ctrl_q <= ctrl_n;
            stat_q <= stat_n;
            fiar_q <= fiar_n;
        end
    end

    assert_save_clears_R9: assert property (@(posedge clk) disable iff (rst)
        save_clr |=> (ctrl_q == '0));

    assert_sticky_status_R12: assert property (@(posedge clk) disable iff (rst)
        (!stat_wr && !rest_ld) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    assert_fiar_capture_R11: assert property (@(posedge clk) disable iff (rst)
        trap |=> (fiar_q == $past(op_addr)));

    assert_fiar_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!trap && !fiar_wr) |=> $stable(fiar_q));
endmodule

// File: rtl/fpx_trap_ctrl.sv
module fpx_trap_ctrl
    import fpx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_class,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        raw_exc,
    input  logic              pred_aware,
    input  logic              cc_nan,
    input  logic              ctrl_wr,
    input  logic [7:0]        ctrl_wdata,
    input  logic              stat_wr,
    input  logic [7:0]        stat_wdata,
    input  logic              fiar_wr,
    input  logic [ADDR_W-1:0] fiar_wdata,
    output logic              trap_req,
    output logic              dst_we,
    output logic              dst_dflt,
    output logic              cond_ok,
    output logic [7:0]        ctrl_q,
    output logic [7:0]        stat_q,
    output logic [ADDR_W-1:0] fiar_q
);
    opc_e     cls;
    verdict_t arith_v;
    verdict_t cond_v;
    verdict_t sel_v;
    logic     save_clr;
    logic     rest_ld;

    assign cls = opc_e'(op_class);

    fpx_arith_judge u_arith (
        .raw     (raw_exc),
        .enables (ctrl_q),
        .verdict (arith_v)
    );

    fpx_cond_judge u_cond (
        .status     (stat_q),
        .enables    (ctrl_q),
        .pred_aware (pred_aware),
        .cc_nan     (cc_nan),
        .verdict    (cond_v)
    );

    always_comb begin
        sel_v    = '0;
        save_clr = 1'b0;
        rest_ld  = 1'b0;
        if (op_valid) begin
            case (cls)
                OPC_ARITH:   sel_v = arith_v;
                OPC_COND:    sel_v = cond_v;
                OPC_SAVE:    save_clr = 1'b1;
                OPC_RESTORE: begin
                    rest_ld    = 1'b1;
                    sel_v.trap = |(raw_exc & ctrl_q);
                end
                default:     sel_v = '0;
            endcase
        end
    end

    fpx_state_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .fiar_wr    (fiar_wr),
        .fiar_wdata (fiar_wdata),
        .save_clr   (save_clr),
        .rest_ld    (rest_ld),
        .rest_val   (raw_exc),
        .set_bits   (sel_v.set_bits),
        .trap       (sel_v.trap),
        .op_addr    (op_addr),
        .ctrl_q     (ctrl_q),
        .stat_q     (stat_q),
        .fiar_q     (fiar_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_req <= 1'b0;
            dst_we   <= 1'b0;
            dst_dflt <= 1'b0;
            cond_ok  <= 1'b0;
        end else begin
            trap_req <= sel_v.trap;
            dst_we   <= sel_v.dst_we;
            dst_dflt <= sel_v.dst_dflt;
            cond_ok  <= sel_v.cond_ok;
        end
    end

    assert_post_blocks_write_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && cls == OPC_ARITH && |(widen_exc(raw_exc) & ctrl_q & POST_MASK))
        |=> (trap_req && !dst_we));

    assert_disabled_writes_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && cls == OPC_ARITH && !(|(widen_exc(raw_exc) & ctrl_q)))
        |=> (dst_we && !trap_req));

    assert_trap_write_default_R4: assert property (@(posedge clk) disable iff (rst)
        (trap_req && dst_we) |-> dst_dflt);

    assert_cond_no_dest_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && cls == OPC_COND) |=> !dst_we);

    assert_moves_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (cls == OPC_CREG || cls == OPC_MREG)) |=> (!trap_req && !dst_we));

    assert_class_legal: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> (op_class <= 3'd5));
endmodule

// File: tb/fpx_trap_ctrl_bench.sv
module fpx_trap_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst;
    logic          op_valid;
    logic [2:0]    op_class;
    logic [AW-1:0] op_addr;
    logic [7:0]    raw_exc;
    logic          pred_aware;
    logic          cc_nan;
    logic          ctrl_wr;
    logic [7:0]    ctrl_wdata;
    logic          stat_wr;
    logic [7:0]    stat_wdata;
    logic          fiar_wr;
    logic [AW-1:0] fiar_wdata;
    logic          trap_req, dst_we, dst_dflt, cond_ok;
    logic [7:0]    ctrl_q, stat_q;
    logic [AW-1:0] fiar_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpx_trap_ctrl #(.ADDR_W(AW)) u_fpx_trap_ctrl (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
        .op_addr(op_addr), .raw_exc(raw_exc), .pred_aware(pred_aware),
        .cc_nan(cc_nan), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .fiar_wr(fiar_wr),
        .fiar_wdata(fiar_wdata), .trap_req(trap_req), .dst_we(dst_we),
        .dst_dflt(dst_dflt), .cond_ok(cond_ok), .ctrl_q(ctrl_q),
        .stat_q(stat_q), .fiar_q(fiar_q)
    );

    // reference model state: values expected after the next rising edge
    int unsigned   m_ctrl, m_stat;
    logic [AW-1:0] m_fiar;
    bit            m_trap, m_we, m_dflt, m_ok;
    string         m_tag;
    int            n_checks = 0;
    int            n_fail = 0;
    bit            finished = 0;

    task automatic model_update();
        int unsigned raw, x, en, nstat, nctrl, setb;
        bit tr, we, df, ok, unord;
        string tag;
        if (rst) begin
            m_ctrl = 0; m_stat = 0; m_fiar = '0;
            m_trap = 0; m_we = 0; m_dflt = 0; m_ok = 0; m_tag = "R1";
            return;
        end
        raw = raw_exc; tr = 0; we = 0; df = 0; ok = 0; setb = 0;
        nstat = stat_wr ? stat_wdata : m_stat;
        nctrl = ctrl_wr ? ctrl_wdata : m_ctrl;
        tag = stat_wr ? "R12" : (fiar_wr ? "R11" : "R8");
        if (op_valid) begin
            case (op_class)
                3'd0: begin
                    x = raw & 32'h7F;
                    if ((raw & 32'h40) != 0) x = x | 32'h20;
                    if ((raw & 32'h3E) != 0) x = x | 32'h01;
                    en = x & m_ctrl;
                    tr = (en != 0);
                    if ((en & 32'h1F) != 0) begin
                        we = 0; df = 0; tag = "R5";
                    end else begin
                        we = 1; df = (x != 0);
                        tag = tr ? "R4" : ((raw & 32'h80) != 0 ? "R13" : ((x != 0) ? "R3" : "R2"));
                    end
                    setb = x;
                end
                3'd1: begin
                    if ((m_stat & m_ctrl) != 0) begin
                        tr = 1; ok = 0; tag = "R7";
                    end else begin
                        unord = !pred_aware && cc_nan;
                        setb = unord ? 32'h80 : 0;
                        tr = unord && ((m_ctrl & 32'h80) != 0);
                        ok = !tr; tag = "R6";
                    end
                end
                3'd3: begin nctrl = 0; tag = "R9"; end
                3'd4: begin tr = ((raw & m_ctrl) != 0); tag = "R10"; end
                default: tag = "R8";
            endcase
        end
        if (op_valid && op_class == 3'd4) nstat = raw;
        else nstat = nstat | setb;
        if (tr) m_fiar = op_addr;
        else if (fiar_wr) m_fiar = fiar_wdata;
        m_ctrl = nctrl & 32'hFF; m_stat = nstat & 32'hFF;
        m_trap = tr; m_we = we; m_dflt = df; m_ok = ok; m_tag = tag;
    endtask

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(m_tag, "trap_req", longint'(trap_req), longint'(m_trap));
        chk(m_tag, "dst_we",   longint'(dst_we),   longint'(m_we));
        chk(m_tag, "dst_dflt", longint'(dst_dflt), longint'(m_dflt));
        chk(m_tag, "cond_ok",  longint'(cond_ok),  longint'(m_ok));
        chk(m_tag, "ctrl_q",   longint'(ctrl_q),   longint'(m_ctrl));
        chk(m_tag, "stat_q",   longint'(stat_q),   longint'(m_stat));
        chk("R11", "fiar_q",   longint'(fiar_q),   longint'(m_fiar));
    endtask

    task automatic idle();
        op_valid = 0; op_class = 3'd2; raw_exc = 0; pred_aware = 1; cc_nan = 0;
        ctrl_wr = 0; stat_wr = 0; fiar_wr = 0;
    endtask

    task automatic step();
        model_update();
        @(posedge clk);
        @(negedge clk);
        compare();
        idle();
        op_addr = op_addr + 4;
    endtask

    task automatic op(input int cls, input int raw);
        op_valid = 1; op_class = 3'(cls); raw_exc = 8'(raw);
        step();
    endtask

    task automatic set_ctrl(input int v);
        ctrl_wr = 1; ctrl_wdata = 8'(v); step();
    endtask

    task automatic set_stat(input int v);
        stat_wr = 1; stat_wdata = 8'(v); step();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        op_addr = 32'h1000; ctrl_wdata = 0; stat_wdata = 0; fiar_wdata = 0;
        idle();
        rst = 1;
        repeat (4) step();          // R1 reset values
        rst = 0;
        step();                     // R1 first cycle out of reset
        op(0, 0);                   // R2/R3 no exception: plain write
        op(0, 8'h08);               // R3 overflow disabled -> default write, inexact paired
        op(0, 8'h40);               // R2 input NaN pairs with input denormal
        set_stat(0);                // R12 explicit clear
        set_ctrl(8'h40);
        op(0, 8'h40);               // R4 enabled pre-instruction trap
        set_stat(0);
        set_ctrl(8'h48);
        op(0, 8'h48);               // R5 post wins over pre
        op(0, 8'h80);               // R13 raw unordered on arith ignored (pending status only)
        set_stat(0);
        set_ctrl(8'h00);
        op_valid = 1; op_class = 3'd1; pred_aware = 0; cc_nan = 1; step(); // R6 disabled
        set_stat(0);
        set_ctrl(8'h80);
        op_valid = 1; op_class = 3'd1; pred_aware = 1; cc_nan = 1; step(); // R6 aware, no trap
        op_valid = 1; op_class = 3'd1; pred_aware = 0; cc_nan = 1; step(); // R6 enabled trap
        op_valid = 1; op_class = 3'd1; pred_aware = 1; cc_nan = 0; step(); // R7 pending
        op(2, 8'hFF);               // R8 control move while pending
        op(5, 8'hFF);               // R8 multi-register move
        ctrl_wr = 1; ctrl_wdata = 8'hFF; op(3, 0); // R9 save beats write
        set_ctrl(8'h02);
        stat_wr = 1; stat_wdata = 8'h11; op(4, 8'h02); // R10 restore beats write, retrap
        op(4, 8'h04);               // R10 restore, not enabled
        fiar_wr = 1; fiar_wdata = 32'hCAFE0000; step(); // R11 software write
        fiar_wr = 1; fiar_wdata = 32'h0BAD0000; op(4, 8'h02); // R11 trap wins
        stat_wr = 1; stat_wdata = 8'h00; op(0, 8'h02); // R12 write merged with new bits
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 70) begin
                op_valid = 1;
                op_class = 3'($urandom_range(0, 5));
                raw_exc = 8'($urandom & $urandom & $urandom);
                pred_aware = 1'($urandom_range(0, 1));
                cc_nan = 1'($urandom_range(0, 1));
            end
            if ($urandom_range(0, 9) == 0) begin ctrl_wr = 1; ctrl_wdata = 8'($urandom & $urandom); end
            if ($urandom_range(0, 7) == 0) begin stat_wr = 1; stat_wdata = 8'($urandom & $urandom); end
            if ($urandom_range(0, 15) == 0) begin fiar_wr = 1; fiar_wdata = $urandom; end
            step();
        end
        finished = 1;
        summary();
    end
endmodule